// File: doc/BRIEF.md
# Hashed Address Channel-Bit Restorer

This block takes a memory address whose channel-select bits were scrambled by a hash and puts those bits back into their plain form. Each candidate channel bit (8, 9, 12, 13 and 14) is flipped when the XOR of its higher-order tap bits, each gated by one of four hash-granule enables, comes to one. Corrections run in ascending bit order. Each correction sees the address as already changed by the earlier ones.

The bits that take part are chosen in one of two ways. In the two vector modes, the block turns the total interleaved channel count into a channel mask, (count − 1) shifted up to bit 8. It then opens a zero gap in that mask: two bits wide at bit 10 for the 1K-style mode, three bits wide at bit 9 for the 2K-style mode. Each set bit of the result marks a channel bit to correct. In the legacy mode, fixed channel-count thresholds pick the bits, and the tap set is slightly different. A bad configuration raises an error flag, and the address then passes through unchanged. The corrected address is registered, so each result appears one clock after its request.

Top module: `dh_dehash`

## Requirements
- R1: Each cycle with `in_valid` high gives `out_valid` high on the next cycle. After a cycle with `in_valid` low, `out_valid` is low and `out_addr` and `out_err` keep their previous values.
- R2: The result is an error (`out_err`=1, `out_addr` equal to `in_addr`) when any of these holds: `intlv_pos` is not 8, `die_cnt` is not 1, `sock_cnt` is greater than 2, `mode` is 3, or `total_chan` is 0.
- R3: `mode` encoding: 0 is legacy, 1 is 2K vector, 2 is 1K vector. In a vector mode, bit b is corrected only if bit b of the gapped mask is set. The mask is ((total_chan−1)<<8) with a zero gap: 3 bits at bit 9 in mode 1, 2 bits at bit 10 in mode 2. Bits at or above the gap move up by the gap width.
- R4: In a vector mode, corrected bit 8+k' (k = 0..4 for bits 8, 9, 12, 13, 14) flips when the XOR of these gated taps is 1: bit 16+k gated by `hash_en[0]`, 21+k by `hash_en[1]`, 30+k by `hash_en[2]`, and 40+k by `hash_en[3]`.
- R5: The tap gated by `hash_en[3]` takes part only in the vector modes. In legacy mode, setting that enable has no effect.
- R6: In legacy mode, bit 8 is always processed, with taps 16, 21 and 30 gated by `hash_en[0..2]`. When `sock_cnt` is 1, bit 14 is also XORed in without a gate.
- R7: In legacy mode, bit 12 is processed (taps 17/22/31) when `total_chan` > 2. Bit 13 is processed (taps 18/23/32) when `total_chan` > 4. Bit 14 is processed (taps 19/24/33) when `total_chan` > 8. Bit 9 is never processed in legacy mode.
- R8: No address bit other than 8, 9, 12, 13 and 14 ever differs between `in_addr` and the `out_addr` it produces.
- R9: While reset is held, `out_valid`, `out_err` and `out_addr` are all zero.
- R10: Corrections run in ascending bit order. In legacy mode with `sock_cnt` = 1, the bit-8 correction uses bit 14 as it is before bit 14 is corrected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe |
| in_addr | input | ADDR_W | Hashed address |
| total_chan | input | CHAN_W | Total interleaved channel count |
| mode | input | 2 | 0 legacy, 1 2K vector, 2 1K vector, 3 reserved |
| intlv_pos | input | POS_W | Interleave start bit, must be 8 |
| die_cnt | input | DIE_W | Interleaved die count, must be 1 |
| sock_cnt | input | SOCK_W | Interleaved socket count, at most 2 |
| hash_en | input | 4 | Granule enables: [0] 64K, [1] 2M, [2] 1G, [3] 1T |
| out_valid | output | 1 | Result strobe |
| out_addr | output | ADDR_W | Corrected address |
| out_err | output | 1 | Configuration error |

## Verification
The corrected address and the error flag go through exactly one register. The block's only other flops are the reset synchronizer. Every result is therefore due on the first rising edge after the cycle its request was presented, and it holds after that until the next request. The bench drives each request just after a falling edge. It compares the outputs at the next falling edge against a behavioural model's prediction for the request of the previous cycle, and it also compares every idle cycle, which checks the hold behaviour. Reset state is compared while reset is still asserted.

// File: rtl/dh_pkg.sv
package dh_pkg;

  typedef enum logic [1:0] {
    DH_LEGACY = 2'd0,
    DH_VEC2K  = 2'd1,
    DH_VEC1K  = 2'd2,
    DH_RSVD   = 2'd3
  } dh_mode_e;

  localparam int NUM_SLOT   = 5;
  localparam int LEG_BASE   = 8;
  localparam int REQ_POS    = 8;

  // address bit corrected by slot k
  function automatic int slot_bit(input int k);
    case (k)
      0:       return 8;
      1:       return 9;
      2:       return 12;
      3:       return 13;
      default: return 14;
    endcase
  endfunction

  // offset of each granule level from the first tap
  function automatic int lvl_off(input int lvl);
    case (lvl)
      0:       return 0;
      1:       return 5;
      2:       return 14;
      default: return 24;
    endcase
  endfunction

  // tap position in the vector modes
  function automatic int vec_tap(input int k, input int lvl);
    return 16 + k + lvl_off(lvl);
  endfunction

  // tap position in legacy mode (slot 1 is unused there)
  function automatic int leg_tap(input int k, input int lvl);
    return (k == 0) ? vec_tap(0, lvl) : vec_tap(k - 1, lvl);
  endfunction

endpackage

// File: rtl/dh_cfg_check.sv
module dh_cfg_check #(
  parameter int CHAN_W = 6,
  parameter int POS_W  = 6,
  parameter int DIE_W  = 4,
  parameter int SOCK_W = 2
) (
  input  logic [CHAN_W-1:0] total_chan,
  input  logic [1:0]        mode,
  input  logic [POS_W-1:0]  intlv_pos,
  input  logic [DIE_W-1:0]  die_cnt,
  input  logic [SOCK_W-1:0] sock_cnt,
  output logic              cfg_err
);
  import dh_pkg::*;

  localparam logic [POS_W-1:0]  POS_OK   = POS_W'(REQ_POS);
  localparam logic [DIE_W-1:0]  DIE_OK   = DIE_W'(1);
  localparam logic [SOCK_W-1:0] SOCK_MAX = SOCK_W'(2);

  logic bad_pos, bad_die, bad_sock, bad_mode, bad_cnt;

  always_comb begin
    bad_pos  = (intlv_pos != POS_OK);
    bad_die  = (die_cnt != DIE_OK);
    bad_sock = (sock_cnt > SOCK_MAX);
    bad_mode = (mode == DH_RSVD);
    bad_cnt  = (total_chan == '0);
    cfg_err  = bad_pos | bad_die | bad_sock | bad_mode | bad_cnt;
  end

endmodule

// File: rtl/dh_slot_sel.sv
module dh_slot_sel #(
  parameter int CHAN_W = 6
) (
  input  logic [CHAN_W-1:0]            total_chan,
  input  logic [1:0]                   mode,
  output logic [dh_pkg::NUM_SLOT-1:0]  slot_en
);
  import dh_pkg::*;

  localparam int GAP_MAX = 3;
  localparam int VEC_W   = CHAN_W + LEG_BASE + GAP_MAX;

  logic [VEC_W-1:0]    chan_mask;
  logic                one_k;
  logic                is_legacy;
  logic [NUM_SLOT-1:0] vec_en;
  logic [NUM_SLOT-1:0] leg_en;

  // bit b of the mask after the gap is opened
  function automatic logic gap_bit(input logic [VEC_W-1:0] v,
                                   input logic one_k_i, input int b);
    int gp;
    int gw;
    gp = one_k_i ? 10 : 9;
    gw = one_k_i ? 2 : 3;
    if (b < gp)           return v[b];
    else if (b < gp + gw) return 1'b0;
    else                  return v[b - gw];
  endfunction

  always_comb begin
    chan_mask = VEC_W'(total_chan - CHAN_W'(1)) << LEG_BASE;
    one_k     = (mode == DH_VEC1K);
    is_legacy = (mode == DH_LEGACY);
  end

  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_vec
    assign vec_en[k] = gap_bit(chan_mask, one_k, slot_bit(k));
  end

  always_comb begin
    leg_en[0] = 1'b1;
    leg_en[1] = 1'b0;
    leg_en[2] = (total_chan > CHAN_W'(2));
    leg_en[3] = (total_chan > CHAN_W'(4));
    leg_en[4] = (total_chan > CHAN_W'(8));
    slot_en   = is_legacy ? leg_en : vec_en;
  end

endmodule

// File: rtl/dh_fix_stage.sv
module dh_fix_stage #(
  parameter int ADDR_W = 52,
  parameter int SLOT   = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              fix_en,
  input  logic              legacy,
  input  logic [3:0]        hash_en,
  input  logic              extra,
  output logic [ADDR_W-1:0] addr_o
);
  import dh_pkg::*;

  localparam int FIX = slot_bit(SLOT);
  localparam int V0  = vec_tap(SLOT, 0);
  localparam int V1  = vec_tap(SLOT, 1);
  localparam int V2  = vec_tap(SLOT, 2);
  localparam int V3  = vec_tap(SLOT, 3);
  localparam int L0  = leg_tap(SLOT, 0);
  localparam int L1  = leg_tap(SLOT, 1);
  localparam int L2  = leg_tap(SLOT, 2);

  logic par_vec, par_leg, par;

  always_comb begin
    par_vec = (addr_i[V0] & hash_en[0]) ^ (addr_i[V1] & hash_en[1]) ^
              (addr_i[V2] & hash_en[2]) ^ (addr_i[V3] & hash_en[3]);
    par_leg = (addr_i[L0] & hash_en[0]) ^ (addr_i[L1] & hash_en[1]) ^
              (addr_i[L2] & hash_en[2]) ^ extra;
    par     = legacy ? par_leg : par_vec;
    addr_o  = addr_i;
    if (fix_en && par) addr_o[FIX] = ~addr_i[FIX];
  end

endmodule

// File: rtl/dh_dehash.sv
module dh_dehash #(
  parameter int ADDR_W = 52,
  parameter int CHAN_W = 6,
  parameter int POS_W  = 6,
  parameter int DIE_W  = 4,
  parameter int SOCK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CHAN_W-1:0] total_chan,
  input  logic [1:0]        mode,
  input  logic [POS_W-1:0]  intlv_pos,
  input  logic [DIE_W-1:0]  die_cnt,
  input  logic [SOCK_W-1:0] sock_cnt,
  input  logic [3:0]        hash_en,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_err
);
  import dh_pkg::*;

  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0]   rst_sync;
  logic                rst_sync_n;
  logic                cfg_err;
  logic [NUM_SLOT-1:0] slot_en;
  logic [NUM_SLOT-1:0] fix_en;
  logic                legacy;
  logic                sock_tap;
  logic [ADDR_W-1:0]   chain [NUM_SLOT+1];

  logic              valid_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic              err_d;
  logic [ADDR_W-1:0] addr_d;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_N-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sync[SYNC_N-1];

  dh_cfg_check #(
    .CHAN_W(CHAN_W), .POS_W(POS_W), .DIE_W(DIE_W), .SOCK_W(SOCK_W)
  ) u_cfg (
    .total_chan(total_chan),
    .mode      (mode),
    .intlv_pos (intlv_pos),
    .die_cnt   (die_cnt),
    .sock_cnt  (sock_cnt),
    .cfg_err   (cfg_err)
  );

  dh_slot_sel #(.CHAN_W(CHAN_W)) u_sel (
    .total_chan(total_chan),
    .mode      (mode),
    .slot_en   (slot_en)
  );

  always_comb begin
    legacy   = (mode == DH_LEGACY);
    fix_en   = cfg_err ? '0 : slot_en;
    sock_tap = legacy && (sock_cnt == SOCK_W'(1)) && in_addr[14];
    chain[0] = in_addr;
  end

  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_fix
    dh_fix_stage #(.ADDR_W(ADDR_W), .SLOT(k)) u_stage (
      .addr_i (chain[k]),
      .fix_en (fix_en[k]),
      .legacy (legacy),
      .hash_en(hash_en),
      .extra  ((k == 0) ? sock_tap : 1'b0),
      .addr_o (chain[k+1])
    );
  end

  // next state
  always_comb begin
    addr_d = chain[NUM_SLOT];
    err_d  = cfg_err;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        addr_q <= addr_d;
        err_q  <= err_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_addr  = addr_q;
  assign out_err   = err_q;

endmodule

// File: rtl/dh_dehash_chk.sv
module dh_dehash_chk #(
  parameter int ADDR_W = 52,
  parameter int CHAN_W = 6,
  parameter int POS_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic [CHAN_W-1:0] total_chan,
  input logic [1:0]        mode,
  input logic [POS_W-1:0]  intlv_pos,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_err
);
  localparam logic [ADDR_W-1:0] FIX_MASK = ADDR_W'(52'h7300);

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_addr) && $stable(out_err)));

  p_bad_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && intlv_pos != POS_W'(8)) |=> (out_err && out_addr == $past(in_addr)));

  p_rsvd_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd3) |=> out_err);

  p_zero_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && total_chan == '0) |=> out_err);

  p_bit9_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode != 2'd2) |=> (out_addr[9] == $past(in_addr[9])));

  p_fix_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (((out_addr ^ $past(in_addr)) & ~FIX_MASK) == '0));

endmodule

bind dh_dehash dh_dehash_chk #(
  .ADDR_W(ADDR_W), .CHAN_W(CHAN_W), .POS_W(POS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_addr   (in_addr),
  .total_chan(total_chan),
  .mode      (mode),
  .intlv_pos (intlv_pos),
  .out_valid (out_valid),
  .out_addr  (out_addr),
  .out_err   (out_err)
);

// File: tb/tb_dh_dehash.sv
`timescale 1ns/1ps
module tb_dh_dehash;
  localparam int AW = 52;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [AW-1:0] in_addr;
  logic [5:0]    total_chan;
  logic [1:0]    mode;
  logic [5:0]    intlv_pos;
  logic [3:0]    die_cnt;
  logic [1:0]    sock_cnt;
  logic [3:0]    hash_en;
  logic          out_valid;
  logic [AW-1:0] out_addr;
  logic          out_err;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  logic          exp_valid = 1'b0;
  logic          exp_err   = 1'b0;
  logic [AW-1:0] exp_addr  = '0;
  string         exp_tag   = "R9";

  always #5 clk = ~clk;

  dh_dehash dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .total_chan(total_chan), .mode(mode), .intlv_pos(intlv_pos),
    .die_cnt(die_cnt), .sock_cnt(sock_cnt), .hash_en(hash_en),
    .out_valid(out_valid), .out_addr(out_addr), .out_err(out_err)
  );

  function automatic logic [AW-1:0] bset(input int b);
    return AW'(1) << b;
  endfunction

  // behavioural reference from the requirements
  function automatic void model(input logic [AW-1:0] a_in, input int total,
      input int md, input int pos, input int dies, input int sock,
      input logic [3:0] en, output logic [AW-1:0] a, output logic err);
    int fb[5] = '{8, 9, 12, 13, 14};
    longint v, lo, hi;
    int gp, gw;
    logic h;
    a   = a_in;
    err = (pos != 8) || (dies != 1) || (sock > 2) || (md == 3) || (total == 0);
    if (err) return;
    if (md == 0) begin
      h = (a[16] & en[0]) ^ (a[21] & en[1]) ^ (a[30] & en[2]) ^ ((sock == 1) ? a[14] : 1'b0);
      if (h) a[8] = ~a[8];
      for (int i = 0; i < 3; i++) begin
        if (total > (2 << i)) begin
          h = (a[17+i] & en[0]) ^ (a[22+i] & en[1]) ^ (a[31+i] & en[2]);
          if (h) a[fb[i+2]] = ~a[fb[i+2]];
        end
      end
    end else begin
      v  = longint'(total - 1) << 8;
      gp = (md == 2) ? 10 : 9;
      gw = (md == 2) ? 2 : 3;
      lo = v % (longint'(1) << gp);
      hi = v >> gp;
      v  = lo + (hi << (gp + gw));
      for (int k = 0; k < 5; k++) begin
        if (((v >> fb[k]) & 1) == 1) begin
          h = (a[16+k] & en[0]) ^ (a[21+k] & en[1]) ^ (a[30+k] & en[2]) ^ (a[40+k] & en[3]);
          if (h) a[fb[k]] = ~a[fb[k]];
        end
      end
    end
  endfunction

  task automatic compare();
    checks++;
    if (out_valid !== exp_valid || out_err !== exp_err || out_addr !== exp_addr) begin
      bad++;
      $display("FAIL %s: got v=%b e=%b a=%h, want v=%b e=%b a=%h", exp_tag,
               out_valid, out_err, out_addr, exp_valid, exp_err, exp_addr);
    end
  endtask

  task automatic step(input bit v, input logic [AW-1:0] a, input int total,
      input int md, input int pos, input int dies, input int sock,
      input logic [3:0] en, input string tag);
    logic [AW-1:0] ea;
    logic ee;
    @(negedge clk);
    compare();
    in_valid   = v;
    in_addr    = a;
    total_chan = 6'(total);
    mode       = 2'(md);
    intlv_pos  = 6'(pos);
    die_cnt    = 4'(dies);
    sock_cnt   = 2'(sock);
    hash_en    = en;
    exp_valid  = v;
    if (v) begin
      model(a, total, md, pos, dies, sock, en, ea, ee);
      exp_addr = ea;
      exp_err  = ee;
      exp_tag  = tag;
    end else begin
      exp_tag = "R1 idle hold";
    end
  endtask

  task automatic go(input logic [AW-1:0] a, input int total, input int md,
      input int sock, input logic [3:0] en, input string tag);
    step(1'b1, a, total, md, 8, 1, sock, en, tag);
  endtask

  task automatic idle();
    step(1'b0, '0, 1, 0, 8, 1, 1, 4'h0, "R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; total_chan = '0; mode = '0;
    intlv_pos = '0; die_cnt = '0; sock_cnt = '0; hash_en = '0;
    repeat (3) begin @(negedge clk); exp_tag = "R9 reset"; compare(); end
    rst_n = 1'b1;
    repeat (3) idle();

    // R4 vector 2K, 16 channels, each slot's first tap
    go(bset(16), 16, 1, 1, 4'hF, "R4 2K bit8 tap16");
    go(bset(18), 16, 1, 1, 4'hF, "R4 2K bit12 tap18");
    go(bset(24) | bset(33), 16, 1, 1, 4'hF, "R4 2K bit13 taps24+33");
    go(bset(34), 16, 1, 1, 4'h4, "R4 2K bit14 tap34");
    go(bset(20), 16, 1, 1, 4'h0, "R4 2K taps gated off");
    // R3 mask/gap selection
    go(bset(17), 4, 2, 1, 4'h1, "R3 1K 4ch bit9 processed");
    go(bset(17), 4, 1, 1, 4'h1, "R3 2K 4ch bit9 skipped");
    go(bset(18), 4, 1, 1, 4'h1, "R3 2K 4ch bit12 processed");
    go(bset(18), 2, 1, 1, 4'h1, "R3 2K 2ch bit12 skipped");
    go(bset(18) | bset(19), 8, 2, 1, 4'h1, "R3 1K 8ch bit12 on bit13 off");
    go(bset(19), 16, 2, 1, 4'h1, "R3 1K 16ch bit13");
    go(bset(18), 3, 1, 1, 4'h1, "R3 2K 3ch odd count");
    idle();
    // R5 top-granule enable
    go(bset(40), 2, 1, 1, 4'h7, "R5 1T disabled");
    go(bset(40), 2, 1, 1, 4'h8, "R5 1T enabled");
    go(bset(42), 16, 2, 1, 4'h8, "R5 1T 1K bit12");
    go(bset(40) | bset(41), 16, 0, 1, 4'hF, "R5 1T ignored legacy");
    // R6 legacy bit 8
    go(bset(14), 2, 0, 1, 4'h0, "R6 legacy sock1 bit14 tap");
    go(bset(14), 2, 0, 2, 4'h0, "R6 legacy sock2 no bit14 tap");
    go(bset(21) | bset(30), 2, 0, 0, 4'h6, "R6 legacy taps21+30");
    go(bset(30), 2, 0, 2, 4'h2, "R6 legacy 1G gated");
    // R7 thresholds
    go(bset(17), 2, 0, 2, 4'h1, "R7 legacy 2ch no bit12");
    go(bset(17), 4, 0, 2, 4'h1, "R7 legacy 4ch bit12");
    go(bset(18), 4, 0, 2, 4'h1, "R7 legacy 4ch no bit13");
    go(bset(18), 8, 0, 2, 4'h1, "R7 legacy 8ch bit13");
    go(bset(19) | bset(33), 8, 0, 2, 4'h5, "R7 legacy 8ch no bit14");
    go(bset(33), 16, 0, 2, 4'h4, "R7 legacy 16ch bit14");
    go(bset(17) | bset(16), 16, 0, 2, 4'h1, "R7 legacy no bit9");
    // R10 ordering
    go(bset(14) | bset(19), 16, 0, 1, 4'h1, "R10 bit8 sees original bit14");
    idle();
    // R2 configuration errors
    step(1'b1, bset(16) | 52'h5A5, 16, 1, 9, 1, 1, 4'hF, "R2 bad pos");
    step(1'b1, bset(16), 16, 1, 8, 2, 1, 4'hF, "R2 die count");
    step(1'b1, bset(16), 16, 1, 8, 1, 3, 4'hF, "R2 socket count");
    step(1'b1, bset(16), 16, 3, 8, 1, 1, 4'hF, "R2 reserved mode");
    step(1'b1, bset(16), 0, 1, 8, 1, 1, 4'hF, "R2 zero count");
    idle();
    idle();
    // R8 random mix, occasional bubbles and errors
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] ra;
      int rt, rm, rs, rp, rd;
      ra = {20'($urandom), $urandom};
      rt = 1 + ($urandom % 16);
      rm = $urandom % 3;
      rs = $urandom % 3;
      rp = (($urandom % 16) == 0) ? 9 : 8;
      rd = (($urandom % 16) == 0) ? 2 : 1;
      if (($urandom % 5) == 0) idle();
      step(1'b1, ra, rt, rm, rp, rd, rs, 4'($urandom), "R8 random");
    end
    idle();
    idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule